// File: doc/BRIEF.md
# Multichannel DAC Update Controller

This block holds the digital side of a sixteen-channel converter. A simple register write port (address, data, strobe) supplies the data. Each channel keeps two 16-bit words. The pending word receives every accepted data or broadcast write. The active word is the code driven to the converter. A per-channel mode bit sets how the active word follows the pending one. In immediate mode it follows at once. In deferred mode it follows only when software writes the load bit of the trigger register.

Neighbouring channels can be joined as a differential pair. A joined pair accepts data only through its even channel, and while any pair is joined the broadcast register has no effect. A keyed code in the trigger register puts every register back to its default. The block also drives a per-channel power-down vector and a one-cycle busy flag.

Top module: `dac_update_ctrl`

## Requirements
- R1: Channel n's data register sits at address 10h+n and holds a 16-bit MSB-aligned word. A write to an address that is not mapped changes no output.
- R2: When bit n of the mode register (06h) is 0, a data write to channel n appears on that channel's code in the cycle after the write.
- R3: When bit n of the mode register is 1, a data write leaves the channel's code unchanged. A trigger write (0Eh) with bit 4 set copies the pending word of every such channel to its code.
- R4: A write to the broadcast register (0Fh) stores its value as the pending word of each channel whose bit in the broadcast mask (05h) is 1. Immediate-mode channels show it at once, and deferred-mode channels wait for the load bit.
- R5: While any bit of the pair register (04h, bits 7:0) is 1, a broadcast write changes no channel.
- R6: Bit k of the pair register joins channels 2k and 2k+1. Writes to channel 2k+1 are discarded, and writes to channel 2k behave normally.
- R7: A trigger write whose bits 3:0 equal 1010 returns every register and code to its reset value, even when bit 4 is also set. Any other value in bits 3:0 has no effect.
- R8: After reset all codes are 0, all mode bits are 0, all broadcast-mask bits are 1, all pair bits are 0, and the power-down register (09h, output pwdn) is all ones. The power-down register is writable.
- R9: busy is 1 for exactly the one cycle after a write that loads at least one channel's code, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 16 | Write data |
| chan_code | output | 256 | Active codes; channel n at bits [16n+15:16n] |
| pwdn | output | 16 | Per-channel power-down bits |
| busy | output | 1 | High for one cycle after any code load |

## Verification
The main update path is tried with several patterns. An immediate write to a single channel shows that its code follows at once. A write to a deferred channel, followed by the load bit, separates the pending word from the active code. A broadcast under a mask that reaches both modes shows that a broadcast goes through the same deferral. A masked-off channel shows that the mask gates the copy. Joining a pair and then writing the odd channel, the even channel and the broadcast register separates discarding from redirection from suppression. Trigger writes with a non-key code, the key code, and key plus load show that only the exact key resets and that reset takes precedence.

// File: rtl/dacu_pkg.sv
package dacu_pkg;
    localparam int unsigned ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_PAIR    = 6'h04;
    localparam logic [ADDR_W-1:0] A_BCMASK  = 6'h05;
    localparam logic [ADDR_W-1:0] A_MODE    = 6'h06;
    localparam logic [ADDR_W-1:0] A_PWDN    = 6'h09;
    localparam logic [ADDR_W-1:0] A_TRIG    = 6'h0E;
    localparam logic [ADDR_W-1:0] A_BCAST   = 6'h0F;
    localparam logic [ADDR_W-1:0] A_DATA0   = 6'h10;

    localparam int unsigned TRIG_LOAD_BIT = 4;
    localparam logic [3:0]  SRST_KEY      = 4'b1010;
endpackage

// File: rtl/dacu_decode.sv
module dacu_decode
    import dacu_pkg::*;
#(
    parameter int unsigned NCH = 16
) (
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [4:0]          trig,
    input  logic [NCH/2-1:0]    pair_en,
    output logic                sel_pair,
    output logic                sel_bcmask,
    output logic                sel_mode,
    output logic                sel_pwdn,
    output logic                bcast_go,
    output logic                load_go,
    output logic                srst_go,
    output logic [NCH-1:0]      chan_go
);
    logic trig_wr;

    always_comb begin
        trig_wr    = wr_en && (wr_addr == A_TRIG);
        srst_go    = trig_wr && (trig[3:0] == SRST_KEY);
        load_go    = trig_wr && trig[TRIG_LOAD_BIT] && !srst_go;
        sel_pair   = wr_en && (wr_addr == A_PAIR);
        sel_bcmask = wr_en && (wr_addr == A_BCMASK);
        sel_mode   = wr_en && (wr_addr == A_MODE);
        sel_pwdn   = wr_en && (wr_addr == A_PWDN);
        bcast_go   = wr_en && (wr_addr == A_BCAST);
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_addr == A_DATA0 + ADDR_W'(i));
        if (i % 2 == 1) begin : g_odd
            // odd member of a joined pair drops its writes
            assign chan_go[i] = hit && !pair_en[i/2];
        end else begin : g_even
            assign chan_go[i] = hit;
        end
    end
endmodule

// File: rtl/dacu_cfg.sv
module dacu_cfg #(
    parameter int unsigned NCH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             sel_pair,
    input  logic             sel_bcmask,
    input  logic             sel_mode,
    input  logic             sel_pwdn,
    input  logic [NCH-1:0]   wdata,
    output logic [NCH/2-1:0] pair_en,
    output logic [NCH-1:0]   bc_mask,
    output logic [NCH-1:0]   sync_en,
    output logic [NCH-1:0]   pwdn
);
    typedef struct packed {
        logic [NCH/2-1:0] pair;
        logic [NCH-1:0]   bcm;
        logic [NCH-1:0]   mode;
        logic [NCH-1:0]   pd;
    } cfg_t;

    localparam cfg_t CFG_RST = '{pair: '0, bcm: '1, mode: '0, pd: '1};

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (srst) begin
            cfg_d = CFG_RST;
        end else begin
            if (sel_pair)   cfg_d.pair = wdata[NCH/2-1:0];
            if (sel_bcmask) cfg_d.bcm  = wdata;
            if (sel_mode)   cfg_d.mode = wdata;
            if (sel_pwdn)   cfg_d.pd   = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign pair_en = cfg_q.pair;
    assign bc_mask = cfg_q.bcm;
    assign sync_en = cfg_q.mode;
    assign pwdn    = cfg_q.pd;
endmodule

// File: rtl/dacu_chan.sv
module dacu_chan #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          sync_en,
    input  logic          wr_go,
    input  logic          bc_go,
    input  logic          load_go,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] code,
    output logic          loaded
);
    typedef struct packed {
        logic [DW-1:0] pend;
        logic [DW-1:0] act;
    } chan_t;

    chan_t st_d, st_q;
    logic  take;

    always_comb begin
        take   = wr_go || bc_go;
        st_d   = st_q;
        loaded = 1'b0;
        if (srst) begin
            st_d = '0;
        end else begin
            if (take) begin
                st_d.pend = wdata;
                if (!sync_en) begin
                    st_d.act = wdata;
                    loaded   = 1'b1;
                end
            end
            if (sync_en && load_go) begin
                st_d.act = st_q.pend;
                loaded   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code = st_q.act;
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import dacu_pkg::*;
#(
    parameter int unsigned NCH = 16,
    parameter int unsigned DW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]     wr_data,
    output logic [NCH*DW-1:0] chan_code,
    output logic [NCH-1:0]    pwdn,
    output logic              busy
);
    logic             sel_pair, sel_bcmask, sel_mode, sel_pwdn;
    logic             bcast_go, load_go, srst_go;
    logic [NCH-1:0]   chan_go, bc_go, loaded;
    logic [NCH/2-1:0] pair_en;
    logic [NCH-1:0]   bc_mask, sync_en;
    logic             any_pair;

    dacu_decode #(.NCH(NCH)) u_dec (
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .trig       (wr_data[4:0]),
        .pair_en    (pair_en),
        .sel_pair   (sel_pair),
        .sel_bcmask (sel_bcmask),
        .sel_mode   (sel_mode),
        .sel_pwdn   (sel_pwdn),
        .bcast_go   (bcast_go),
        .load_go    (load_go),
        .srst_go    (srst_go),
        .chan_go    (chan_go)
    );

    dacu_cfg #(.NCH(NCH)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst       (srst_go),
        .sel_pair   (sel_pair),
        .sel_bcmask (sel_bcmask),
        .sel_mode   (sel_mode),
        .sel_pwdn   (sel_pwdn),
        .wdata      (wr_data[NCH-1:0]),
        .pair_en    (pair_en),
        .bc_mask    (bc_mask),
        .sync_en    (sync_en),
        .pwdn       (pwdn)
    );

    // broadcast is dropped entirely while any pair is joined
    assign any_pair = |pair_en;
    assign bc_go    = (bcast_go && !any_pair) ? bc_mask : '0;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        dacu_chan #(.DW(DW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .srst    (srst_go),
            .sync_en (sync_en[i]),
            .wr_go   (chan_go[i]),
            .bc_go   (bc_go[i]),
            .load_go (load_go),
            .wdata   (wr_data),
            .code    (chan_code[i*DW +: DW]),
            .loaded  (loaded[i])
        );
    end

    typedef struct packed {
        logic busy;
    } top_t;

    top_t top_d, top_q;

    always_comb begin
        top_d      = top_q;
        top_d.busy = |loaded;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign busy = top_q.busy;
endmodule

// File: rtl/dacu_checker.sv
module dacu_checker
    import dacu_pkg::*;
#(
    parameter int unsigned NCH = 16,
    parameter int unsigned DW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DW-1:0]     wr_data,
    input logic [NCH*DW-1:0] chan_code,
    input logic [NCH-1:0]    pwdn,
    input logic              busy,
    input logic [NCH-1:0]    sync_en,
    input logic [NCH/2-1:0]  pair_en
);
    logic t_wr, t_srst, t_load, b_wr;
    assign t_wr   = wr_en && (wr_addr == A_TRIG);
    assign t_srst = t_wr && (wr_data[3:0] == SRST_KEY);
    assign t_load = t_wr && wr_data[TRIG_LOAD_BIT];
    assign b_wr   = wr_en && (wr_addr == A_BCAST);

    p_srst_defaults_r7: assert property (@(posedge clk) disable iff (!rst_n)
        t_srst |=> (chan_code == '0) && (&pwdn) && !busy);

    p_busy_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $past(wr_en));

    p_bcast_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (b_wr && (|pair_en)) |=> $stable(chan_code));

    for (genvar i = 0; i < NCH; i++) begin : g_ck
        logic hit;
        assign hit = wr_en && (wr_addr == A_DATA0 + ADDR_W'(i));

        p_sync_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (sync_en[i] && !t_load && !t_srst) |=> $stable(chan_code[i*DW +: DW]));

        if (i % 2 == 1) begin : g_odd
            p_pair_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && pair_en[i/2]) |=> $stable(chan_code[i*DW +: DW]));
            p_async_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && !sync_en[i] && !pair_en[i/2]) |=> (chan_code[i*DW +: DW] == $past(wr_data)));
        end else begin : g_even
            p_async_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && !sync_en[i]) |=> (chan_code[i*DW +: DW] == $past(wr_data)));
        end
    end
endmodule

bind dac_update_ctrl dacu_checker #(.NCH(NCH), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .chan_code (chan_code),
    .pwdn      (pwdn),
    .busy      (busy),
    .sync_en   (sync_en),
    .pair_en   (pair_en)
);

// File: tb/sim_dac_update_ctrl.sv
`timescale 1ns/1ps
module sim_dac_update_ctrl;
    localparam int NCH = 16;
    localparam int DW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [5:0]        wr_addr = '0;
    logic [DW-1:0]     wr_data = '0;
    logic [NCH*DW-1:0] chan_code;
    logic [NCH-1:0]    pwdn;
    logic              busy;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    dac_update_ctrl #(.NCH(NCH), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .chan_code(chan_code), .pwdn(pwdn), .busy(busy)
    );

    // {addr, data, channel checked, expected code, requirement number}
    localparam int NV = 16;
    localparam logic [45:0] VEC [0:NV-1] = '{
        {6'h10, 16'hA5A5, 4'd0,  16'hA5A5, 4'd2},  // R2 immediate write ch0
        {6'h1F, 16'h1234, 4'd15, 16'h1234, 4'd1},  // R1 last data address
        {6'h06, 16'h0002, 4'd0,  16'hA5A5, 4'd3},  // R3 ch1 to deferred mode
        {6'h11, 16'hBEEF, 4'd1,  16'h0000, 4'd3},  // R3 deferred write held
        {6'h0E, 16'h0010, 4'd1,  16'hBEEF, 4'd3},  // R3 load bit
        {6'h0F, 16'h5555, 4'd3,  16'h5555, 4'd4},  // R4 broadcast immediate
        {6'h0E, 16'h0010, 4'd1,  16'h5555, 4'd4},  // R4 broadcast deferred
        {6'h05, 16'hFFFE, 4'd0,  16'h5555, 4'd4},  // R4 mask ch0 off
        {6'h0F, 16'h7777, 4'd0,  16'h5555, 4'd4},  // R4 masked channel kept
        {6'h00, 16'h0000, 4'd2,  16'h7777, 4'd1},  // R1 unmapped address
        {6'h04, 16'h0002, 4'd3,  16'h7777, 4'd6},  // R6 join ch2/ch3
        {6'h13, 16'h9999, 4'd3,  16'h7777, 4'd6},  // R6 odd write discarded
        {6'h12, 16'h4444, 4'd2,  16'h4444, 4'd6},  // R6 even write taken
        {6'h0F, 16'h1111, 4'd4,  16'h7777, 4'd5},  // R5 broadcast suppressed
        {6'h0E, 16'h0005, 4'd4,  16'h7777, 4'd7},  // R7 non-key code
        {6'h0E, 16'h000A, 4'd4,  16'h0000, 4'd7}   // R7 key code
    };

    function automatic logic [DW-1:0] code_of(input int ch);
        return chan_code[ch*DW +: DW];
    endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write at a negedge; on return the next negedge has come, outputs are settled
    task automatic wr(input logic [5:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        begin
            logic all_zero;
            all_zero = 1'b1;
            for (int c = 0; c < NCH; c++) if (code_of(c) != '0) all_zero = 1'b0;
            check("R8 codes zero", {15'd0, all_zero}, 16'd1);
        end
        check("R8 pwdn all ones", pwdn, 16'hFFFF);
        check("R8 busy low", {15'd0, busy}, 16'd0);

        for (int v = 0; v < NV; v++) begin
            string tag;
            wr(VEC[v][45:40], VEC[v][39:24]);
            tag = $sformatf("R%0d vector %0d", VEC[v][3:0], v);
            check(tag, code_of(int'(VEC[v][23:20])), VEC[v][19:4]);
        end

        // R7 reset by key: power-down back to ones, busy stays low
        check("R7 pwdn restored", pwdn, 16'hFFFF);
        check("R7 busy low on reset", {15'd0, busy}, 16'd0);

        wr(6'h09, 16'h0000);
        check("R8 pwdn writable", pwdn, 16'h0000);
        wr(6'h0E, 16'h000A);
        check("R7 pwdn after key", pwdn, 16'hFFFF);

        // R7 mode bits cleared: ch1 now immediate; R9 busy pulse
        wr(6'h11, 16'h0F0F);
        check("R7 ch1 immediate after key", code_of(1), 16'h0F0F);
        check("R9 busy after load", {15'd0, busy}, 16'd1);
        @(negedge clk);
        check("R9 busy one cycle", {15'd0, busy}, 16'd0);

        wr(6'h06, 16'h0001);
        wr(6'h10, 16'h2222);
        check("R9 no busy on deferred write", {15'd0, busy}, 16'd0);
        check("R3 ch0 held", code_of(0), 16'h0000);

        // R7 key plus load bit: reset wins, pending word discarded
        wr(6'h0E, 16'h001A);
        check("R7 key beats load", code_of(0), 16'h0000);
        check("R7 busy low key+load", {15'd0, busy}, 16'd0);
        wr(6'h10, 16'h3333);
        check("R7 ch0 immediate again", code_of(0), 16'h3333);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule